// File: doc/BRIEF.md
# Memory Pattern Self-Test Controller

This block is a synthesizable built-in self-test sequencer for a small single-port memory. The memory reads asynchronously and commits a write on the rising edge of a write strobe. After a one-cycle start request, the controller drives the memory's address, write-data and strobe lines itself. It works through five phases in a fixed order:

1. Fill every location with all zeros.
2. Verify the zeros.
3. Fill every location with all ones.
4. Verify the ones.
5. Per address, write and read back an alternating pattern, then write and read back its complement.

The controller stops on the first wrong read. It then holds the phase, address, observed byte and expected byte for inspection. If no read is wrong, it raises a pass flag.

All access timing is counted in system-clock cycles:

- **Write (four cycles):** address with the strobe low, then data with the strobe still low, then the strobe rises, then one idle cycle.
- **Read (three cycles):** the address is applied, the read bus is sampled two clock edges later, then one idle cycle.

The outputs are registered, so the memory sees clean levels and a glitch-free strobe edge.

Top module: `mem_pattern_bist`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the strobe is high and busy, done, pass and fail are all low.
- R2: A start request while idle raises busy in the next cycle and launches phase 1 at address 0. A start request while busy has no effect on the access sequence or its outcome.
- R3: Within each phase, addresses are visited in ascending order from 0 to DEPTH-1.
- R4: A write lasts four cycles:
  - cycle 1: the address is driven with the strobe low;
  - cycle 2: the data is driven with the strobe still low;
  - cycle 3: the strobe is high with the address and data unchanged;
  - cycle 4: idle, with everything held.
- R5: A read keeps the strobe high and holds the address for three cycles. The read bus is compared on the second clock edge after the address appears.
- R6: Phase order: phase 1 writes 0x00 everywhere, phase 2 expects 0x00, phase 3 writes 0xFF everywhere, and phase 4 expects 0xFF.
- R7: Phase 5 handles one address at a time: write 0x55, read and expect 0x55, write 0xAA, read and expect 0xAA, then move to the next address.
- R8: On the first mismatch the controller behaves as follows:
  - in the next cycle busy falls and done and fail rise;
  - fail_phase (1 to 5), fail_addr, fail_rdata and fail_expect show the failing read;
  - no further access occurs;
  - the record and the memory lines stay unchanged until the next start.
- R9: When the last read of phase 5 matches, busy falls after that read's idle cycle and done and pass rise.
- R10: A new start clears done, pass, fail and the whole failure record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a test run |
| mem_addr | output | AW (9) | Address to the memory under test |
| mem_wdata | output | DW (8) | Write data to the memory |
| mem_wstrobe | output | 1 | Write strobe; its rising edge commits data |
| mem_rdata | input | DW (8) | Asynchronous read data from the memory |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| pass | output | 1 | The last run finished with no mismatch |
| fail | output | 1 | The last run stopped on a mismatch |
| fail_phase | output | 3 | Phase of the failing read (1 to 5) |
| fail_addr | output | AW (9) | Address of the failing read |
| fail_rdata | output | DW (8) | Byte observed at the failing read |
| fail_expect | output | DW (8) | Byte that was expected |

## Verification
The controller is exercised against a behavioural memory in four configurations:

- **Healthy memory:** confirms the full pass path and the exact timing of every access.
- **Bit 0 stuck high at address 300:** the solid-zero verify phase must catch this.
- **Bit 6 stuck low at address 77:** the solid-zero phase cannot see this; only the solid-ones verify can.
- **Last address drops writes of 0x55:** both solid fills see a healthy cell, so only the alternating readback of phase 5 exposes it.

Each fault therefore separates one phase from the others. The halt is checked for the correct phase, address, observed byte and expected byte.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int unsigned PH_W  = 3;
  localparam int unsigned SUB_W = 2;

  localparam logic [PH_W-1:0]  PH_FIRST = 3'd1;
  localparam logic [PH_W-1:0]  PH_LAST  = 3'd5;
  localparam logic [SUB_W-1:0] SUB_LAST = 2'd3;

  typedef enum logic [1:0] {
    PAT_ZERO  = 2'd0,
    PAT_ONE   = 2'd1,
    PAT_ALT01 = 2'd2,   // bit 0 set, alternating upward (0x55 for 8 bits)
    PAT_ALT10 = 2'd3    // complement of PAT_ALT01
  } pat_e;

  typedef struct packed {
    logic wr;           // 1: write access, 0: read-and-compare access
    pat_e pat;
  } step_t;

  // Decode a (phase, sub-step) pair into the access it performs.
  function automatic step_t step_of(logic [PH_W-1:0] ph, logic [SUB_W-1:0] sub);
    step_t s;
    unique case (ph)
      3'd1:    s = '{wr: 1'b1, pat: PAT_ZERO};
      3'd2:    s = '{wr: 1'b0, pat: PAT_ZERO};
      3'd3:    s = '{wr: 1'b1, pat: PAT_ONE};
      3'd4:    s = '{wr: 1'b0, pat: PAT_ONE};
      default: s = '{wr: ~sub[0], pat: (sub[1] ? PAT_ALT10 : PAT_ALT01)};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter  int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [AW-1:0] addr,
  output logic          at_last
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign at_last = (addr == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) addr <= '0;
    else if (inc)   addr <= addr + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    inc |-> !at_last) else $error("address stepped past the top"); // R3

endmodule

// File: rtl/mbist_step_ctl.sv
module mbist_step_ctl
  import mbist_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic             addr_last,
  output logic [PH_W-1:0]  phase,
  output logic [SUB_W-1:0] sub,
  output logic [PH_W-1:0]  nxt_phase,
  output logic [SUB_W-1:0] nxt_sub,
  output logic             addr_inc,
  output logic             addr_wrap,
  output logic             seq_last
);

  always_comb begin
    nxt_phase = phase;
    nxt_sub   = sub;
    addr_inc  = 1'b0;
    addr_wrap = 1'b0;
    if (phase != PH_LAST) begin
      // solid phases: one access per address, then move on to the next phase
      if (addr_last) begin
        nxt_phase = phase + 1'b1;
        addr_wrap = 1'b1;
      end else begin
        addr_inc = 1'b1;
      end
    end else if (sub != SUB_LAST) begin
      nxt_sub = sub + 1'b1;
    end else begin
      nxt_sub  = '0;
      addr_inc = 1'b1;
    end
  end

  assign seq_last = (phase == PH_LAST) && (sub == SUB_LAST) && addr_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= PH_FIRST;
      sub   <= '0;
    end else if (adv) begin
      phase <= nxt_phase;
      sub   <= nxt_sub;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase >= PH_FIRST) && (phase <= PH_LAST)) else $error("phase out of range"); // R6

  AST_SUB_IDLE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_LAST) |-> (sub == '0)) else $error("sub-step outside phase 5"); // R7

endmodule

// File: rtl/mbist_compare.sv
module mbist_compare #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] observed,
  input  logic [DW-1:0] expected,
  output logic          mismatch
);

  // Case inequality: an unknown or floating read bit counts as an error.
  assign mismatch = (observed !== expected);

endmodule

// File: rtl/mem_pattern_bist.sv
module mem_pattern_bist
  import mbist_pkg::*;
#(
  parameter  int DEPTH = 512,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wstrobe,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [PH_W-1:0]  fail_phase,
  output logic [AW-1:0]    fail_addr,
  output logic [DW-1:0]    fail_rdata,
  output logic [DW-1:0]    fail_expect
);

  localparam logic [1:0] W_DATA = 2'd0, W_RISE = 2'd1, W_HOLD = 2'd2;
  localparam logic [1:0] R_WAIT = 2'd0, R_SAMP = 2'd1;

  function automatic logic [DW-1:0] pat_bits(pat_e p);
    logic [DW-1:0] v;
    for (int i = 0; i < DW; i++) begin
      unique case (p)
        PAT_ZERO:  v[i] = 1'b0;
        PAT_ONE:   v[i] = 1'b1;
        PAT_ALT01: v[i] = (i % 2 == 0);
        default:   v[i] = (i % 2 == 1);
      endcase
    end
    return v;
  endfunction

  logic [1:0]       slot;
  logic [PH_W-1:0]  phase, nxt_phase;
  logic [SUB_W-1:0] sub, nxt_sub;
  logic             addr_inc, addr_wrap, seq_last, addr_last;
  logic             launch, adv, mismatch;
  step_t            cur_s, nxt_s, first_s;
  logic [DW-1:0]    cur_pat;

  assign launch  = start && !busy;
  assign cur_s   = step_of(phase, sub);
  assign nxt_s   = step_of(nxt_phase, nxt_sub);
  assign first_s = step_of(PH_FIRST, '0);
  assign cur_pat = pat_bits(cur_s.pat);
  assign adv     = busy && (cur_s.wr ? (slot == 2'd3) : ((slot == 2'd2) && !seq_last));

  mbist_step_ctl u_step (
    .clk       (clk),
    .rst       (rst),
    .clr       (launch),
    .adv       (adv),
    .addr_last (addr_last),
    .phase     (phase),
    .sub       (sub),
    .nxt_phase (nxt_phase),
    .nxt_sub   (nxt_sub),
    .addr_inc  (addr_inc),
    .addr_wrap (addr_wrap),
    .seq_last  (seq_last)
  );

  mbist_addr_gen #(.DEPTH(DEPTH)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .clr     (launch || (adv && addr_wrap)),
    .inc     (adv && addr_inc),
    .addr    (mem_addr),
    .at_last (addr_last)
  );

  mbist_compare #(.DW(DW)) u_cmp (
    .observed (mem_rdata),
    .expected (cur_pat),
    .mismatch (mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
      mem_wstrobe <= 1'b1;
      mem_wdata   <= '0;
      slot        <= '0;
      fail_phase  <= '0;
      fail_addr   <= '0;
      fail_rdata  <= '0;
      fail_expect <= '0;
    end else if (!busy) begin
      if (start) begin
        busy        <= 1'b1;
        done        <= 1'b0;
        pass        <= 1'b0;
        fail        <= 1'b0;
        slot        <= '0;
        mem_wstrobe <= ~first_s.wr;
        fail_phase  <= '0;
        fail_addr   <= '0;
        fail_rdata  <= '0;
        fail_expect <= '0;
      end
    end else if (cur_s.wr) begin
      unique case (slot)
        W_DATA:  begin mem_wdata <= cur_pat; slot <= 2'd1; end
        W_RISE:  begin mem_wstrobe <= 1'b1;  slot <= 2'd2; end
        W_HOLD:  slot <= 2'd3;
        default: begin slot <= '0; mem_wstrobe <= nxt_s.wr ? 1'b0 : 1'b1; end
      endcase
    end else begin
      unique case (slot)
        R_WAIT: slot <= 2'd1;
        R_SAMP: begin
          if (mismatch) begin
            busy        <= 1'b0;
            done        <= 1'b1;
            fail        <= 1'b1;
            slot        <= '0;
            fail_phase  <= phase;
            fail_addr   <= mem_addr;
            fail_rdata  <= mem_rdata;
            fail_expect <= cur_pat;
          end else begin
            slot <= 2'd2;
          end
        end
        default: begin
          slot <= '0;
          if (seq_last) begin
            busy <= 1'b0;
            done <= 1'b1;
            pass <= 1'b1;
          end else begin
            mem_wstrobe <= nxt_s.wr ? 1'b0 : 1'b1;
          end
        end
      endcase
    end
  end

  AST_IDLE_STROBE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mem_wstrobe) else $error("strobe low while idle"); // R8

  AST_STROBE_LOW_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wstrobe) |=> !mem_wstrobe ##1 mem_wstrobe) else $error("strobe low width"); // R4

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wstrobe) |-> $stable(mem_addr) && $stable(mem_wdata)) else $error("setup broken"); // R4

  AST_FAIL_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> mem_wstrobe && $stable(mem_addr)) else $error("early sample"); // R5

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail) && !(busy && done)) else $error("flag clash"); // R9

  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail && $stable(fail_addr) && $stable(fail_rdata)
                         && $stable(fail_expect) && $stable(fail_phase)) else $error("record moved"); // R8

endmodule

// File: tb/mem_pattern_bist_tb.sv
`timescale 1ns/1ps
module mem_pattern_bist_tb_top;

  localparam int DEPTH = 512;
  localparam int DW    = 8;
  localparam int AW    = 9;
  localparam logic [DW-1:0] FILL = 8'h3C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_wstrobe;
  logic          busy, done, pass, fail;
  logic [2:0]    fail_phase;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_rdata, fail_expect;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mem_pattern_bist dut_i (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrobe(mem_wstrobe),
    .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_phase(fail_phase), .fail_addr(fail_addr),
    .fail_rdata(fail_rdata), .fail_expect(fail_expect)
  );

  // Fault model: 0 healthy, 1 bit stuck high, 2 bit stuck low, 3 writes of 0x55 dropped.
  int fault_kind = 0;
  int fault_addr = 0;
  int fault_bit  = 0;

  logic [DW-1:0] cells [DEPTH];
  logic [DW-1:0] ref_cells [DEPTH];

  function automatic logic [DW-1:0] faulty_read(logic [DW-1:0] v, int a);
    logic [DW-1:0] r;
    r = v;
    if (a == fault_addr) begin
      if (fault_kind == 1) r[fault_bit] = 1'b1;
      else if (fault_kind == 2) r[fault_bit] = 1'b0;
    end
    return r;
  endfunction

  function automatic bit write_lost(int a, logic [DW-1:0] d);
    return (fault_kind == 3) && (a == fault_addr) && (d == 8'h55);
  endfunction

  // Memory under test: commit on the rising strobe edge, asynchronous read.
  always @(posedge mem_wstrobe)
    if (!write_lost(int'(mem_addr), mem_wdata)) cells[mem_addr] = mem_wdata;

  always_comb mem_rdata = faulty_read(cells[mem_addr], int'(mem_addr));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: one entry per clock cycle of expected port values.
  typedef struct {
    bit sb;
    int a;
    bit dchk;
    int d;
  } cyc_t;

  cyc_t trace[$];
  bit   e_fail;
  int   e_phase, e_addr, e_rd, e_exp;

  task automatic ref_wr(int a, int d);
    // R4: address+strobe low, data+strobe low, strobe high, idle
    trace.push_back('{sb: 1'b0, a: a, dchk: 1'b0, d: 0});
    trace.push_back('{sb: 1'b0, a: a, dchk: 1'b1, d: d});
    trace.push_back('{sb: 1'b1, a: a, dchk: 1'b1, d: d});
    trace.push_back('{sb: 1'b1, a: a, dchk: 1'b1, d: d});
    if (!write_lost(a, DW'(d))) ref_cells[a] = DW'(d);
  endtask

  task automatic ref_rd(int ph, int a, int ex);
    logic [DW-1:0] v;
    v = faulty_read(ref_cells[a], a);
    // R5: address held with strobe high; compared on the second edge
    trace.push_back('{sb: 1'b1, a: a, dchk: 1'b0, d: 0});
    trace.push_back('{sb: 1'b1, a: a, dchk: 1'b0, d: 0});
    if (v != DW'(ex)) begin
      e_fail = 1'b1; e_phase = ph; e_addr = a; e_rd = int'(v); e_exp = ex;
    end else begin
      trace.push_back('{sb: 1'b1, a: a, dchk: 1'b0, d: 0});
    end
  endtask

  task automatic build_trace();
    trace.delete();
    e_fail = 1'b0;
    for (int a = 0; a < DEPTH; a++) ref_cells[a] = FILL;
    // R6 phases 1..4 and R3 ascending addresses
    for (int ph = 1; ph <= 4; ph++)
      for (int a = 0; a < DEPTH; a++)
        if (!e_fail) begin
          if (ph == 1)      ref_wr(a, 8'h00);
          else if (ph == 2) ref_rd(ph, a, 8'h00);
          else if (ph == 3) ref_wr(a, 8'hFF);
          else              ref_rd(ph, a, 8'hFF);
        end
    // R7 phase 5 per-address alternating readback
    for (int a = 0; a < DEPTH; a++) begin
      if (!e_fail) ref_wr(a, 8'h55);
      if (!e_fail) ref_rd(5, a, 8'h55);
      if (!e_fail) ref_wr(a, 8'hAA);
      if (!e_fail) ref_rd(5, a, 8'hAA);
    end
  endtask

  task automatic do_run(string name, bit poke);
    logic [AW-1:0] hold_a;
    for (int a = 0; a < DEPTH; a++) cells[a] = FILL;
    build_trace();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R10: the previous record is cleared on the first cycle of a new run
    chk(!done && !pass && !fail && fail_phase == 0 && fail_addr == 0 &&
        fail_rdata == 0 && fail_expect == 0, "R10", {name, " flags cleared"},
        int'(fail_addr), 0);
    for (int k = 0; k < trace.size(); k++) begin
      bit ok;
      ok = busy && !done && !pass && !fail &&
           (mem_wstrobe == trace[k].sb) && (int'(mem_addr) == trace[k].a) &&
           (!trace[k].dchk || int'(mem_wdata) == trace[k].d);
      chk(ok, (trace[k].sb && !trace[k].dchk) ? "R5" : "R4",
          $sformatf("%s cycle %0d strobe/addr", name, k),
          int'({mem_wstrobe, mem_addr}), int'({trace[k].sb, AW'(trace[k].a)}));
      if (!ok) break;
      // R2: a start request in the middle of a run must not disturb the trace
      start = poke && (k == 1000);
      @(negedge clk);
    end
    start = 1'b0;
    if (e_fail) begin
      chk(!busy && done && fail && !pass, "R8", {name, " halt flags"},
          int'({busy, done, pass, fail}), 4'b0101);
      chk(int'(fail_phase) == e_phase, "R8", {name, " fail_phase"}, int'(fail_phase), e_phase);
      chk(int'(fail_addr) == e_addr, "R8", {name, " fail_addr"}, int'(fail_addr), e_addr);
      chk(int'(fail_rdata) == e_rd, "R8", {name, " fail_rdata"}, int'(fail_rdata), e_rd);
      chk(int'(fail_expect) == e_exp, "R8", {name, " fail_expect"}, int'(fail_expect), e_exp);
    end else begin
      chk(!busy && done && pass && !fail, poke ? "R2" : "R9", {name, " pass flags"},
          int'({busy, done, pass, fail}), 4'b0110);
    end
    hold_a = mem_addr;
    repeat (4) @(negedge clk);
    chk(!busy && mem_wstrobe && mem_addr == hold_a, "R8", {name, " no access after end"},
        int'(mem_addr), int'(hold_a));
    if (e_fail)
      chk(fail && int'(fail_addr) == e_addr && int'(fail_phase) == e_phase, "R8",
          {name, " record held"}, int'(fail_addr), e_addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_wstrobe && !busy && !done && !pass && !fail, "R1", "in reset",
        int'({mem_wstrobe, busy, done, pass, fail}), 5'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_wstrobe && !busy && !done && !pass && !fail, "R1", "after reset",
        int'({mem_wstrobe, busy, done, pass, fail}), 5'b10000);

    fault_kind = 0;
    do_run("healthy", 1'b1);

    fault_kind = 1; fault_addr = 300; fault_bit = 0;
    do_run("stuck-high", 1'b0);       // R6 expect phase 2 halt

    fault_kind = 2; fault_addr = 77; fault_bit = 6;
    do_run("stuck-low", 1'b0);        // R6 expect phase 4 halt

    fault_kind = 3; fault_addr = DEPTH - 1;
    do_run("lost-write", 1'b0);       // R7 expect phase 5 halt at the top address

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule